// File: doc/BRIEF.md
# Vectored Interrupt Group Arbiter

This block collects interrupt events from up to 36 sources and hands the most urgent pending one to the processor. Each source has its own group, and each group carries exactly one vector. The number of the winning group therefore names the interrupt directly, and no handler has to demultiplex it further. Each group keeps a pending flag, an enable bit and a 3-bit urgency level. Level 0 is the most urgent, level 6 is the least urgent, and level 7 masks the group.

On every clock the arbiter looks at all groups that are pending, enabled and not masked. It selects the one with the numerically smallest level and registers the result. It raises the request line only when that level is strictly more urgent than the level the processor is currently running at. Software configures the groups through a small write port, and reads their state through a combinational read port.

Top module: `vic_vec_arb`

## Requirements
- R1: After reset every group holds level 7, enable 0 and flag 0. The outputs are `irq_req`=0, `irq_level`=7 and `irq_grp`=0.
- R2: A one-cycle `src_pulse[g]` sets the flag of group g at the next clock edge. The flag then stays set while the group is disabled or masked. `rd_data` for an in-range `rd_grp` is {flag, enable, level[2:0]}, with flag in bit 4, enable in bit 3 and level in bits 2:0.
- R3: A write with `wr_data[4]`=1 clears the flag of the addressed group. When a source pulse for that group arrives in the same cycle, the flag stays set.
- R4: A write with `wr_en`=1 loads `wr_data[2:0]` as the group's level and `wr_data[3]` as its enable. A write whose `wr_grp` is 36 or above changes nothing. A read of such an index returns 5'b00111.
- R5: A group at level 7 never wins arbitration and never causes a request.
- R6: Among groups that are pending and enabled and have a level below 7, the smallest level is reported on `irq_level`.
- R7: When several candidates share the smallest level, the lowest-numbered group is reported on `irq_grp`.
- R8: `irq_req` is 1 only when a candidate exists and its level is strictly less than `cpu_level` as sampled in the same cycle as the group state.
- R9: The outputs are registered. They reflect the group state and `cpu_level` present in the cycle before the clock edge that updates them, so a source pulse shows up at the outputs two edges later.
- R10: With no candidate, `irq_level` reads 7 and `irq_grp` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pulse | input | 36 | One-cycle event per group |
| cpu_level | input | 3 | Level the processor currently runs at |
| wr_en | input | 1 | Configuration write strobe |
| wr_grp | input | 6 | Group index for the write |
| wr_data | input | 5 | Bit 4 clears the flag, bit 3 is the enable, bits 2:0 are the level |
| rd_grp | input | 6 | Group index for the read |
| rd_data | output | 5 | {flag, enable, level} of `rd_grp` |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_level | output | 3 | Level of the winning group |
| irq_grp | output | 6 | Number of the winning group |

## Verification
A pulse or a write becomes visible on `rd_data` one edge after it is driven. It reaches `irq_req`, `irq_level` and `irq_grp` one edge after that, because the arbitration result is registered on top of the group state. The bench drives inputs on the falling edge and updates its model in the same order. It predicts the registered outputs from the model state and the `cpu_level` of the cycle being driven, then compares them at the following falling edge. Directed sequences cover the following cases:
- masking, and pending while disabled
- equal-level ties
- a clear that collides with a pulse
- out-of-range writes
- a `cpu_level` equal to the winning level

Seeded random traffic covers the remaining cases.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int LVL_W   = 3;
    localparam int CFG_W   = 5;
    localparam int EN_BIT  = 3;
    localparam int CLR_BIT = 4;
    localparam logic [LVL_W-1:0] LVL_OFF = '1;
endpackage

// File: rtl/vic_group_bank.sv
module vic_group_bank
    import vic_pkg::*;
#(
    parameter int NUM_GRP = 36,
    parameter int GRP_W   = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_GRP-1:0]             src_pulse,
    input  logic                           wr_en,
    input  logic [GRP_W-1:0]               wr_grp,
    input  logic [CFG_W-1:0]               wr_data,
    input  logic [GRP_W-1:0]               rd_grp,
    output logic [CFG_W-1:0]               rd_data,
    output logic [NUM_GRP-1:0][LVL_W-1:0]  lvl_o,
    output logic [NUM_GRP-1:0]             cand_o
);
    typedef struct packed {
        logic [NUM_GRP-1:0][LVL_W-1:0] lvl;
        logic [NUM_GRP-1:0]            en;
        logic [NUM_GRP-1:0]            flag;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [NUM_GRP-1:0] wr_hit;
    logic               clr_req;

    assign clr_req = wr_data[CLR_BIT];

    // Address decode: one hit line per group; out-of-range indices hit nothing (R4).
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_dec
        assign wr_hit[g] = wr_en && (wr_grp == GRP_W'(g));
    end

    always_comb begin
        bank_d = bank_q;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (wr_hit[g]) begin
                bank_d.lvl[g] = wr_data[LVL_W-1:0];
                bank_d.en[g]  = wr_data[EN_BIT];
            end
            // A new event outranks a clear in the same cycle (R3).
            bank_d.flag[g] = (bank_q.flag[g] && !(wr_hit[g] && clr_req)) || src_pulse[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.lvl  <= {NUM_GRP{LVL_OFF}};
            bank_q.en   <= '0;
            bank_q.flag <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        rd_data = {2'b00, LVL_OFF};
        if (int'(rd_grp) < NUM_GRP) begin
            rd_data = {bank_q.flag[rd_grp], bank_q.en[rd_grp], bank_q.lvl[rd_grp]};
        end
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_cand
        assign cand_o[g] = bank_q.flag[g] && bank_q.en[g] && (bank_q.lvl[g] != LVL_OFF);
        assign lvl_o[g]  = bank_q.lvl[g];

        p_pulse_sets_r2 : assert property (@(posedge clk) disable iff (!rst_n)
            src_pulse[g] |=> bank_q.flag[g]);

        p_clear_works_r3 : assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit[g] && clr_req && !src_pulse[g]) |=> !bank_q.flag[g]);

        p_flag_holds_r2 : assert property (@(posedge clk) disable iff (!rst_n)
            (!src_pulse[g] && !wr_hit[g]) |=> (bank_q.flag[g] == $past(bank_q.flag[g])));

        p_cfg_untouched_r4 : assert property (@(posedge clk) disable iff (!rst_n)
            !wr_hit[g] |=> (bank_q.lvl[g] == $past(bank_q.lvl[g])) && (bank_q.en[g] == $past(bank_q.en[g])));
    end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
#(
    parameter int NUM_GRP = 36,
    parameter int GRP_W   = 6
) (
    input  logic [NUM_GRP-1:0][LVL_W-1:0] lvl_i,
    input  logic [NUM_GRP-1:0]            cand_i,
    output logic                          win_valid,
    output logic [LVL_W-1:0]              win_lvl,
    output logic [GRP_W-1:0]              win_grp
);
    // Strict compare while scanning upward keeps the lowest index on ties (R7).
    always_comb begin
        win_lvl = LVL_OFF;
        win_grp = '0;
        for (int i = 0; i < NUM_GRP; i++) begin
            if (cand_i[i] && (lvl_i[i] < win_lvl)) begin
                win_lvl = lvl_i[i];
                win_grp = GRP_W'(i);
            end
        end
        win_valid = (win_lvl != LVL_OFF);
    end

    always_comb begin
        if (win_valid) begin
            a_win_is_cand_r6 : assert (cand_i[win_grp] && (lvl_i[win_grp] == win_lvl));
        end
        if (cand_i == '0) begin
            a_none_r10 : assert (!win_valid && (win_grp == '0));
        end
    end
endmodule

// File: rtl/vic_vec_arb.sv
module vic_vec_arb
    import vic_pkg::*;
#(
    parameter int NUM_GRP = 36,
    parameter int GRP_W   = $clog2(NUM_GRP)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_GRP-1:0]   src_pulse,
    input  logic [LVL_W-1:0]     cpu_level,
    input  logic                 wr_en,
    input  logic [GRP_W-1:0]     wr_grp,
    input  logic [CFG_W-1:0]     wr_data,
    input  logic [GRP_W-1:0]     rd_grp,
    output logic [CFG_W-1:0]     rd_data,
    output logic                 irq_req,
    output logic [LVL_W-1:0]     irq_level,
    output logic [GRP_W-1:0]     irq_grp
);
    typedef struct packed {
        logic             req;
        logic [LVL_W-1:0] lvl;
        logic [GRP_W-1:0] grp;
    } out_t;

    logic [NUM_GRP-1:0][LVL_W-1:0] grp_lvl;
    logic [NUM_GRP-1:0]            grp_cand;
    logic                          win_valid;
    logic [LVL_W-1:0]              win_lvl;
    logic [GRP_W-1:0]              win_grp;
    out_t                          out_d, out_q;

    vic_group_bank #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_pulse (src_pulse),
        .wr_en     (wr_en),
        .wr_grp    (wr_grp),
        .wr_data   (wr_data),
        .rd_grp    (rd_grp),
        .rd_data   (rd_data),
        .lvl_o     (grp_lvl),
        .cand_o    (grp_cand)
    );

    vic_arbiter #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W)) u_arb (
        .lvl_i     (grp_lvl),
        .cand_i    (grp_cand),
        .win_valid (win_valid),
        .win_lvl   (win_lvl),
        .win_grp   (win_grp)
    );

    always_comb begin
        out_d.req = win_valid && (win_lvl < cpu_level);
        out_d.lvl = win_valid ? win_lvl : LVL_OFF;
        out_d.grp = win_valid ? win_grp : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.req <= 1'b0;
            out_q.lvl <= LVL_OFF;
            out_q.grp <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_req   = out_q.req;
    assign irq_level = out_q.lvl;
    assign irq_grp   = out_q.grp;

    p_req_better_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_level < $past(cpu_level)));

    p_masked_quiet_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_level != LVL_OFF));

    p_idle_grp_zero_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == LVL_OFF) |-> (!irq_req && irq_grp == '0));

    p_latency_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        $past(grp_cand == '0) |-> !irq_req);
endmodule

// File: tb/tb_vic_vec_arb.sv
`timescale 1ns/1ps
module tb_vic_vec_arb;
    localparam int N  = 36;
    localparam int GW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_pulse = '0;
    logic [2:0]    cpu_level = 3'd0;
    logic          wr_en = 1'b0;
    logic [GW-1:0] wr_grp = '0;
    logic [4:0]    wr_data = '0;
    logic [GW-1:0] rd_grp = '0;
    logic [4:0]    rd_data;
    logic          irq_req;
    logic [2:0]    irq_level;
    logic [GW-1:0] irq_grp;

    vic_vec_arb dut (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .cpu_level(cpu_level),
        .wr_en(wr_en), .wr_grp(wr_grp), .wr_data(wr_data), .rd_grp(rd_grp),
        .rd_data(rd_data), .irq_req(irq_req), .irq_level(irq_level), .irq_grp(irq_grp)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [2:0]    m_lvl [N];
    logic          m_en  [N];
    logic          m_flag[N];
    logic          e_req;
    logic [2:0]    e_lvl;
    logic [GW-1:0] e_grp;
    logic [GW-1:0] rd_prev;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [4:0] model_rd(logic [GW-1:0] g);
        if (int'(g) >= N) return 5'b00111;
        return {m_flag[g], m_en[g], m_lvl[g]};
    endfunction

    // One cycle: check results due now, drive new inputs, predict, advance model.
    task automatic cycle(string tag, logic [N-1:0] p, logic we, logic [GW-1:0] wg,
                         logic [4:0] wd, logic [2:0] cl, logic [GW-1:0] rg);
        logic [2:0]    bl;
        logic [GW-1:0] bg;
        @(negedge clk);
        chk(tag, "R8 irq_req",   int'(irq_req),   int'(e_req));
        chk(tag, "R6 irq_level", int'(irq_level), int'(e_lvl));
        chk(tag, "R7 irq_grp",   int'(irq_grp),   int'(e_grp));
        chk(tag, "R2 rd_data",   int'(rd_data),   int'(model_rd(rd_prev)));
        src_pulse = p; wr_en = we; wr_grp = wg; wr_data = wd; cpu_level = cl; rd_grp = rg;
        rd_prev = rg;
        bl = 3'd7; bg = '0;
        for (int i = 0; i < N; i++)
            if (m_flag[i] && m_en[i] && m_lvl[i] != 3'd7 && m_lvl[i] < bl) begin
                bl = m_lvl[i]; bg = GW'(i);
            end
        e_lvl = bl; e_grp = bg; e_req = (bl != 3'd7) && (bl < cl);
        for (int i = 0; i < N; i++) begin
            if (we && wg == GW'(i)) begin
                m_lvl[i] = wd[2:0];
                m_en[i]  = wd[3];
                if (wd[4]) m_flag[i] = 1'b0;
            end
            if (p[i]) m_flag[i] = 1'b1;
        end
    endtask

    function automatic logic [N-1:0] bitn(int g);
        logic [N-1:0] v = '0;
        v[g] = 1'b1;
        return v;
    endfunction

    initial begin
        for (int i = 0; i < N; i++) begin m_lvl[i] = 3'd7; m_en[i] = 0; m_flag[i] = 0; end
        e_req = 0; e_lvl = 3'd7; e_grp = '0; rd_prev = '0;
        repeat (3) @(negedge clk);
        chk("R1", "irq_req in reset",   int'(irq_req),   0);
        chk("R1", "irq_level in reset", int'(irq_level), 7);
        chk("R1", "irq_grp in reset",   int'(irq_grp),   0);
        rst_n = 1'b1;
        // R1: every group reads level 7, disabled, no flag
        for (int g = 0; g < N; g++) cycle("R1", '0, 0, '0, '0, 3'd7, GW'(g));
        // R4: configure group 5, write to out-of-range index 40
        cycle("R4", '0, 1, 6'd5, 5'b01011, 3'd7, 6'd5);
        cycle("R4", '0, 1, 6'd40, 5'b01000, 3'd7, 6'd40);
        cycle("R4", '0, 0, '0, '0, 3'd7, 6'd40);
        // R2: group 9 pending while disabled at level 2
        cycle("R2", '0, 1, 6'd9, 5'b00010, 3'd7, 6'd9);
        cycle("R2", bitn(9), 0, '0, '0, 3'd7, 6'd9);
        cycle("R2", '0, 0, '0, '0, 3'd7, 6'd9);
        cycle("R2", '0, 0, '0, '0, 3'd7, 6'd9);
        // R9: enable group 9, request appears two edges later
        cycle("R9", '0, 1, 6'd9, 5'b01010, 3'd7, 6'd9);
        cycle("R9", '0, 0, '0, '0, 3'd7, 6'd9);
        cycle("R9", '0, 0, '0, '0, 3'd7, 6'd9);
        // R7: group 4 joins at level 2, lower index wins
        cycle("R7", bitn(4), 1, 6'd4, 5'b01010, 3'd7, 6'd4);
        cycle("R7", '0, 0, '0, '0, 3'd7, 6'd4);
        cycle("R7", '0, 0, '0, '0, 3'd7, 6'd4);
        // R8: cpu at level 2 blocks, at 3 allows, at 0 blocks
        cycle("R8", '0, 0, '0, '0, 3'd2, 6'd4);
        cycle("R8", '0, 0, '0, '0, 3'd3, 6'd4);
        cycle("R8", '0, 0, '0, '0, 3'd0, 6'd4);
        cycle("R8", '0, 0, '0, '0, 3'd0, 6'd4);
        // R5/R10: mask both, nothing requests, idle outputs
        cycle("R5", '0, 1, 6'd4, 5'b01111, 3'd7, 6'd4);
        cycle("R5", '0, 1, 6'd9, 5'b01111, 3'd7, 6'd9);
        cycle("R10", '0, 0, '0, '0, 3'd7, 6'd9);
        cycle("R10", '0, 0, '0, '0, 3'd7, 6'd9);
        // R3: clear collides with pulse, then clear alone
        cycle("R3", bitn(9), 1, 6'd9, 5'b11001, 3'd7, 6'd9);
        cycle("R3", '0, 0, '0, '0, 3'd7, 6'd9);
        cycle("R3", '0, 1, 6'd9, 5'b11001, 3'd7, 6'd9);
        cycle("R3", '0, 0, '0, '0, 3'd7, 6'd9);
        cycle("R3", '0, 0, '0, '0, 3'd7, 6'd9);
        // Random traffic
        void'($urandom(32'd1234));
        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0] p;
            for (int i = 0; i < N; i++) p[i] = ($urandom % 10) == 0;
            cycle("rnd", p, ($urandom % 2) == 1, GW'($urandom), 5'($urandom),
                  3'($urandom), GW'($urandom));
        end
        cycle("end", '0, 0, '0, '0, 3'd7, '0);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
        end
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule